// File: doc/BRIEF.md
# Twisted-Pair Receive Polarity Corrector

This block sits behind the receive decoder of a 10BASE-T port and decides whether the twisted pair is wired with its two conductors swapped. The decoder reports single-cycle event strobes:
- a link pulse in the expected orientation, or one that arrived upside down;
- the end of a frame whose start-of-idle was normal, or one whose start-of-idle was inverted.

The block keeps two separate runs of evidence. One run counts wrong-way link pulses. The other counts frames with an inverted start-of-idle. Each run has its own threshold. When either run reaches its threshold, the block toggles an invert control that feeds the receive path. It also raises a one-cycle change strobe.

A timed return covers a link that has gone silent. While the port reports link fail and nothing arrives for a whole window of millisecond ticks, the invert control goes back to normal polarity. When link testing is turned off, link pulses are ignored entirely, and only frames drive the decision. All state uses a synchronous active-high reset. Both outputs are registered.

Top module: `rx_polarity_corrector`

## Requirements
- R1: After reset, `o_invert` is 0 and `o_flip` is 0.
- R2: With link testing on, `o_invert` toggles on the clock edge that takes the 16th inverted link pulse (`PULSE_RUN`) in a row. Fifteen in a row leave it unchanged.
- R3: A correctly oriented link pulse restarts the wrong-pulse run, so a declaration then needs a full new run of 16.
- R4: `o_invert` toggles on the edge that takes the 4th frame (`FRAME_RUN`) with an inverted start-of-idle. A frame ending with a normal start-of-idle restarts that run.
- R5: `o_flip` is high for exactly one cycle, in the cycle after each change of `o_invert`, and is never high at any other time.
- R6: Every change of `o_invert` clears both evidence runs.
- R7: When `i_link_fail` has been held with no activity for `SILENCE_MS` ticks of `i_ms_tick` (default 112), `o_invert` returns to 0 on the edge that takes the last tick. One tick fewer leaves it set.
- R8: Activity restarts the silence window, as does any cycle with `i_link_fail` low. Activity means any frame strobe, or any link-pulse strobe while link testing is on.
- R9: With `i_link_test_en` low, link-pulse strobes do not count toward reversal and do not count as activity. Frame strobes still work as usual.
- R10: A declaration made while `o_invert` is 1 toggles it back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_pulse_ok | input | 1 | Strobe: link pulse in the expected orientation |
| i_pulse_inv | input | 1 | Strobe: link pulse received upside down |
| i_frame_ok | input | 1 | Strobe: frame ended with a normal start-of-idle |
| i_frame_inv | input | 1 | Strobe: frame ended with an inverted start-of-idle |
| i_link_fail | input | 1 | Level: port is in link fail |
| i_link_test_en | input | 1 | Level: link integrity testing is enabled |
| i_ms_tick | input | 1 | One-cycle strobe once per millisecond |
| o_invert | output | 1 | Registered invert control to the receive path |
| o_flip | output | 1 | Registered one-cycle strobe on each change of `o_invert` |

## Verification
The assertions check properties that hold on every cycle:
- an evidence run clears after a good event or a threshold hit;
- a run stays frozen while its input is disabled, and grows by exactly one per bad event otherwise;
- the silence timer sits at zero whenever link fail is low;
- `o_invert` changes only together with `o_flip`.

Some behaviour needs the bench's scenarios, because only a sequence of events can show it:
- the exact count at which a declaration happens, and that one event fewer does not trigger it;
- that a change of polarity clears the other evidence run as well;
- the exact tick on which the silence window expires;
- that a link pulse sent while link testing is off neither adds evidence nor restarts the window.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;

  // Default thresholds shared by the block and its bench.
  localparam int unsigned DEF_PULSE_RUN  = 16;
  localparam int unsigned DEF_FRAME_RUN  = 4;
  localparam int unsigned DEF_SILENCE_MS = 112;

  // A pair of opposing evidence strobes for one stream.
  typedef struct packed {
    logic good;
    logic bad;
  } rxpol_evt_t;

endpackage

// File: rtl/rxpol_run_counter.sv
module rxpol_run_counter
  import rxpol_pkg::*;
#(
  parameter int unsigned RUN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       clr,
  input  rxpol_evt_t evt,
  output logic       hit
);

  localparam int unsigned CW = (RUN > 2) ? $clog2(RUN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  logic [CW-1:0] cnt;
  logic          bump;

  assign bump = en && evt.bad && !evt.good;

  generate
    if (RUN <= 1) begin : g_single
      assign hit = bump;
    end else begin : g_run
      assign hit = bump && (cnt == LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr || hit) begin
      cnt <= '0;
    end else if (en && evt.good) begin
      cnt <= '0;
    end else if (bump) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3 / R4: a good event restarts the run
  p_good_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (en && evt.good) |=> (cnt == '0));

  // R6: a run is empty after a threshold hit or an external clear
  p_hit_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (hit || clr) |=> (cnt == '0));

  // R2: each bad event below the threshold adds exactly one
  p_bad_counts_r2: assert property (@(posedge clk) disable iff (rst)
    (bump && !hit && !clr) |=> (cnt == $past(cnt) + 1'b1));

  // R9: a disabled stream leaves the run untouched
  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/rxpol_silence_timer.sv
module rxpol_silence_timer #(
  parameter int unsigned WINDOW = 112
) (
  input  logic clk,
  input  logic rst,
  input  logic link_fail,
  input  logic activity,
  input  logic tick,
  output logic expire
);

  localparam int unsigned TW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [TW-1:0] LAST = TW'(WINDOW - 1);

  logic [TW-1:0] cnt;

  assign expire = link_fail && !activity && tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !link_fail || activity || expire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R8: window restarts whenever link fail is low or activity is seen
  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (!link_fail || activity) |=> (cnt == '0));

  // R7: window starts over after it expires
  p_expire_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt == '0));

  // R7: without a tick the window does not advance
  p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (link_fail && !activity && !tick) |=> $stable(cnt));

endmodule

// File: rtl/rx_polarity_corrector.sv
module rx_polarity_corrector
  import rxpol_pkg::*;
#(
  parameter int unsigned PULSE_RUN  = DEF_PULSE_RUN,
  parameter int unsigned FRAME_RUN  = DEF_FRAME_RUN,
  parameter int unsigned SILENCE_MS = DEF_SILENCE_MS
) (
  input  logic clk,
  input  logic rst,
  input  logic i_pulse_ok,
  input  logic i_pulse_inv,
  input  logic i_frame_ok,
  input  logic i_frame_inv,
  input  logic i_link_fail,
  input  logic i_link_test_en,
  input  logic i_ms_tick,
  output logic o_invert,
  output logic o_flip
);

  rxpol_evt_t pulse_evt;
  rxpol_evt_t frame_evt;
  logic       pulse_hit;
  logic       frame_hit;
  logic       declare;
  logic       silent_expire;
  logic       restore;
  logic       change;
  logic       activity;

  assign pulse_evt = '{good: i_pulse_ok, bad: i_pulse_inv};
  assign frame_evt = '{good: i_frame_ok, bad: i_frame_inv};

  assign activity = (i_link_test_en && (i_pulse_ok || i_pulse_inv))
                  || i_frame_ok || i_frame_inv;

  assign declare = pulse_hit || frame_hit;
  assign restore = silent_expire && o_invert;
  assign change  = declare || restore;

  rxpol_run_counter #(.RUN(PULSE_RUN)) u_pulse_run (
    .clk (clk),
    .rst (rst),
    .en  (i_link_test_en),
    .clr (change),
    .evt (pulse_evt),
    .hit (pulse_hit)
  );

  rxpol_run_counter #(.RUN(FRAME_RUN)) u_frame_run (
    .clk (clk),
    .rst (rst),
    .en  (1'b1),
    .clr (change),
    .evt (frame_evt),
    .hit (frame_hit)
  );

  rxpol_silence_timer #(.WINDOW(SILENCE_MS)) u_silence (
    .clk       (clk),
    .rst       (rst),
    .link_fail (i_link_fail),
    .activity  (activity),
    .tick      (i_ms_tick),
    .expire    (silent_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_invert <= 1'b0;
      o_flip   <= 1'b0;
    end else begin
      o_flip <= change;
      if (declare) begin
        o_invert <= !o_invert;
      end else if (restore) begin
        o_invert <= 1'b0;
      end
    end
  end

  // R5: flip strobe marks a real change of the invert control
  p_flip_means_change_r5: assert property (@(posedge clk) disable iff (rst)
    o_flip |-> (o_invert != $past(o_invert)));

  // R5: invert never changes silently
  p_change_has_flip_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(o_invert) |-> o_flip);

  // R7: a silent return always lands on normal polarity
  p_restore_normal_r7: assert property (@(posedge clk) disable iff (rst)
    (restore && !declare) |=> !o_invert);

endmodule

// File: tb/test_rx_polarity_corrector.sv
module test_rx_polarity_corrector;
  import rxpol_pkg::*;

  localparam int unsigned WIN = DEF_SILENCE_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_pulse_ok = 0, i_pulse_inv = 0, i_frame_ok = 0, i_frame_inv = 0;
  logic i_link_fail = 0, i_link_test_en = 1, i_ms_tick = 0;
  logic o_invert, o_flip;

  int n_checks = 0;
  int n_fail   = 0;
  int flip_seen = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_polarity_corrector i_rx_polarity_corrector (
    .clk(clk), .rst(rst),
    .i_pulse_ok(i_pulse_ok), .i_pulse_inv(i_pulse_inv),
    .i_frame_ok(i_frame_ok), .i_frame_inv(i_frame_inv),
    .i_link_fail(i_link_fail), .i_link_test_en(i_link_test_en),
    .i_ms_tick(i_ms_tick),
    .o_invert(o_invert), .o_flip(o_flip)
  );

  always @(negedge clk) if (!rst && o_flip) flip_seen++;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 pulse ok, 1 pulse inv, 2 frame ok, 3 frame inv, 4 ms tick
  task automatic ev(input int kind, input int times);
    for (int i = 0; i < times; i++) begin
      @(negedge clk);
      case (kind)
        0: i_pulse_ok  = 1;
        1: i_pulse_inv = 1;
        2: i_frame_ok  = 1;
        3: i_frame_inv = 1;
        default: i_ms_tick = 1;
      endcase
      @(negedge clk);
      {i_pulse_ok, i_pulse_inv, i_frame_ok, i_frame_inv, i_ms_tick} = '0;
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 invert", o_invert, 0);
    chk("R1 flip", o_flip, 0);
  endtask

  task automatic t_pulses();
    ev(1, 10); ev(0, 1); ev(1, 15);
    chk("R3 broken run", o_invert, 0);
    ev(1, 1);
    chk("R2 sixteenth pulse", o_invert, 1);
    chk("R5 flip high", o_flip, 1);
    @(negedge clk);
    chk("R5 flip one cycle", o_flip, 0);
  endtask

  task automatic t_frames();
    ev(3, 3); ev(2, 1); ev(3, 3);
    chk("R4 normal frame restarts", o_invert, 1);
    ev(3, 1);
    chk("R10 toggle back", o_invert, 0);
    chk("R4 flip", o_flip, 1);
  endtask

  task automatic t_clear();
    ev(3, 3); ev(1, 16);
    chk("R2 after frames", o_invert, 1);
    ev(3, 1);
    chk("R6 frame run cleared", o_invert, 1);
    ev(3, 3);
    chk("R6 full new frame run", o_invert, 0);
  endtask

  task automatic t_lit_off();
    i_link_test_en = 0;
    ev(1, 20);
    chk("R9 pulses ignored", o_invert, 0);
    ev(3, 4);
    chk("R9 frames still count", o_invert, 1);
    i_link_test_en = 1;
  endtask

  task automatic t_silence();
    i_link_fail = 1;
    ev(4, 50); ev(2, 1); ev(4, WIN - 1);
    chk("R8 activity restarts", o_invert, 1);
    ev(4, 1);
    chk("R7 expire", o_invert, 0);
    chk("R7 flip", o_flip, 1);
    i_link_fail = 0;
    ev(3, 4);
    chk("R4 set again", o_invert, 1);
    i_link_fail = 1;
    ev(4, 100);
    @(negedge clk) i_link_fail = 0;
    @(negedge clk) i_link_fail = 1;
    i_link_test_en = 0;
    ev(4, 60); ev(0, 1); ev(4, WIN - 61);
    chk("R8 link-fail drop restarts", o_invert, 1);
    ev(4, 1);
    chk("R9 pulse not activity", o_invert, 0);
    i_link_fail = 0;
    i_link_test_en = 1;
    @(negedge clk);
    chk("R5 total flips", flip_seen, 8);
  endtask

  initial begin
    t_reset();
    t_pulses();
    t_frames();
    t_clear();
    t_lit_off();
    t_silence();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule